// File: doc/BRIEF.md
# Speculative-Segment Adder

A purely combinational binary adder that cuts its operands into equal-width segments. The lowest segment adds with the external carry-in. Every higher segment is built twice and both copies run at the same time: one assumes an incoming carry of 0, the other assumes 1. When the real carry arrives from the segment below, a bank of 2:1 selectors picks the matching sum. The segment's own carry-out comes from a reduced form rather than from a full selector. With an incoming carry of 1 it is the carry of the carry-in-1 copy. With an incoming carry of 0 it is the AND of both copies' carries. This AND form is valid because the carry-in-0 copy can only produce a carry when the carry-in-1 copy also does.

Inside each segment, the adder is a chain of 4-bit carry-lookahead cells that use generate and propagate terms. The width and the segment size are parameters. The default is a 16-bit adder made from 8-bit segments. An 8-bit adder made from 4-bit segments is the second supported form. The block has no clock and no handshake, and it is meant to sit inside a timed path of a larger datapath. The stream-style handshake is left out because the block has no storage.

Top module: `csa_adder`

## Requirements
- R1: For every pair of 16-bit operands and carry-in, `sum` equals the low 16 bits of `opa + opb + cin` (default parameters WIDTH=16, SEG_W=8).
- R2: `cout` equals bit 16 of `opa + opb + cin`.
- R3: With WIDTH=8 and SEG_W=4, `sum` and `cout` equal the 9-bit result of `opa + opb + cin`.
- R4: A carry entering at `cin` reaches every segment. All-ones plus zero with `cin`=1 gives `sum`=0 and `cout`=1 in both forms.
- R5: In every upper segment, the carry of the carry-in-0 copy implies the carry of the carry-in-1 copy.
- R6: The carry leaving each upper segment equals the carry-in-1 copy's carry when the incoming carry is 1, and the carry-in-0 copy's carry when it is 0.
- R7: All-zero operands with `cin`=0 give `sum`=0 and `cout`=0.
- R8: Alternating-bit operands (0xAAAA + 0x5555) give all ones with no carry when `cin`=0. The same operands with `cin`=1 give zero with a carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First addend |
| opb | input | WIDTH | Second addend |
| cin | input | 1 | Carry into the lowest segment |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top segment |

## Verification
The block holds no state, so a wrong selector choice or a wrong speculative carry shows at the ports as soon as the inputs settle. It appears as a corrupted upper segment of `sum` or as a wrong `cout` for that same operand pair. The faults that matter most hide behind a specific carry: a segment carry of 1 that must ripple through every higher segment, or an incoming carry of 0 that must see the AND form. The chosen vectors therefore force full carry propagation, zero propagation and alternating patterns alongside random operands.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // width of one carry-lookahead cell
  localparam int CLA_W = 4;
endpackage

// File: rtl/csa_cla4.sv
module csa_cla4
  import csa_pkg::*;
(
  input  logic [CLA_W-1:0] a,
  input  logic [CLA_W-1:0] b,
  input  logic             ci,
  output logic [CLA_W-1:0] s,
  output logic             co
);
  logic [CLA_W-1:0] gen, prop;
  logic [CLA_W:0]   cy;

  assign gen  = a & b;
  assign prop = a ^ b;

  // flattened lookahead: each carry depends only on g, p and ci
  always_comb begin
    cy[0] = ci;
    for (int i = 0; i < CLA_W; i++) begin
      logic term;
      logic chain;
      term  = 1'b0;
      for (int j = 0; j <= i; j++) begin
        chain = gen[j];
        for (int k = j + 1; k <= i; k++) chain = chain & prop[k];
        term = term | chain;
      end
      chain = ci;
      for (int k = 0; k <= i; k++) chain = chain & prop[k];
      cy[i+1] = term | chain;
    end
  end

  assign s  = prop ^ cy[CLA_W-1:0];
  assign co = cy[CLA_W];
endmodule

// File: rtl/csa_segadd.sv
module csa_segadd
  import csa_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             ci,
  output logic [SEG_W-1:0] s,
  output logic             co
);
  localparam int NCELL = SEG_W / CLA_W;
  logic [NCELL:0] link;

  assign link[0] = ci;
  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    csa_cla4 u_cell (
      .a (a[c*CLA_W +: CLA_W]),
      .b (b[c*CLA_W +: CLA_W]),
      .ci(link[c]),
      .s (s[c*CLA_W +: CLA_W]),
      .co(link[c+1])
    );
  end
  assign co = link[NCELL];
endmodule

// File: rtl/csa_seg_select.sv
module csa_seg_select #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] s_zero,
  input  logic [SEG_W-1:0] s_one,
  input  logic             c_zero,
  input  logic             c_one,
  input  logic             pick,
  output logic [SEG_W-1:0] s_out,
  output logic             c_out
);
  // one 2:1 selector per sum bit
  for (genvar i = 0; i < SEG_W; i++) begin : g_mux
    assign s_out[i] = pick ? s_one[i] : s_zero[i];
  end
  // reduced carry: AND form when the incoming carry is low
  assign c_out = c_one & (pick | c_zero);
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int WIDTH = 16,
  parameter int SEG_W = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSEG = WIDTH / SEG_W;

  logic [NSEG:0]     segc;
  logic [NSEG-1:1]   spec_c0, spec_c1;

  csa_segadd #(.SEG_W(SEG_W)) u_low (
    .a (opa[SEG_W-1:0]),
    .b (opb[SEG_W-1:0]),
    .ci(cin),
    .s (sum[SEG_W-1:0]),
    .co(segc[1])
  );
  assign segc[0] = cin;

  for (genvar k = 1; k < NSEG; k++) begin : g_hi
    logic [SEG_W-1:0] s0, s1;
    csa_segadd #(.SEG_W(SEG_W)) u_zero (
      .a (opa[k*SEG_W +: SEG_W]),
      .b (opb[k*SEG_W +: SEG_W]),
      .ci(1'b0),
      .s (s0),
      .co(spec_c0[k])
    );
    csa_segadd #(.SEG_W(SEG_W)) u_one (
      .a (opa[k*SEG_W +: SEG_W]),
      .b (opb[k*SEG_W +: SEG_W]),
      .ci(1'b1),
      .s (s1),
      .co(spec_c1[k])
    );
    csa_seg_select #(.SEG_W(SEG_W)) u_sel (
      .s_zero(s0),
      .s_one (s1),
      .c_zero(spec_c0[k]),
      .c_one (spec_c1[k]),
      .pick  (segc[k]),
      .s_out (sum[k*SEG_W +: SEG_W]),
      .c_out (segc[k+1])
    );
  end

  assign cout = segc[NSEG];
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
  parameter int WIDTH = 16,
  parameter int SEG_W = 8
) (
  input logic [WIDTH-1:0]       opa,
  input logic [WIDTH-1:0]       opb,
  input logic                   cin,
  input logic [WIDTH-1:0]       sum,
  input logic                   cout,
  input logic [WIDTH/SEG_W:0]   segc,
  input logic [WIDTH/SEG_W-1:1] spec_c0,
  input logic [WIDTH/SEG_W-1:1] spec_c1
);
  localparam int NSEG = WIDTH / SEG_W;
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    // R1
    sum_value_chk: assert (sum == ref_total[WIDTH-1:0]);
    // R2
    carry_out_chk: assert (cout == ref_total[WIDTH]);
    for (int k = 1; k < NSEG; k++) begin
      // R5
      spec_order_chk: assert (!spec_c0[k] || spec_c1[k]);
      // R6
      seg_carry_chk: assert (segc[k+1] == (segc[k] ? spec_c1[k] : spec_c0[k]));
    end
  end
endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_chk (
  .opa    (opa),
  .opb    (opb),
  .cin    (cin),
  .sum    (sum),
  .cout   (cout),
  .segc   (segc),
  .spec_c0(spec_c0),
  .spec_c1(spec_c1)
);

// File: tb/tb_csa_adder.sv
module tb_csa_adder;
  logic clk = 1'b0;
  always #2ns clk = ~clk;  // 250 MHz

  logic [15:0] a16, b16, s16;
  logic [7:0]  a8, b8, s8;
  logic        ci, co16, co8;

  csa_adder #(.WIDTH(16), .SEG_W(8)) dut (
    .opa(a16), .opb(b16), .cin(ci), .sum(s16), .cout(co16));
  csa_adder #(.WIDTH(8), .SEG_W(4)) dut8 (
    .opa(a8), .opb(b8), .cin(ci), .sum(s8), .cout(co8));

  typedef struct {
    logic [16:0] exp16;
    logic [8:0]  exp8;
    string       tag;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  task automatic drive(input logic [15:0] x, input logic [15:0] y,
                       input logic c, input string tag);
    item_t it;
    @(posedge clk);
    #1ns;
    a16 = x; b16 = y; a8 = x[7:0]; b8 = y[7:0]; ci = c;
    it.exp16 = {1'b0, x} + {1'b0, y} + {16'd0, c};
    it.exp8  = {1'b0, x[7:0]} + {1'b0, y[7:0]} + {8'd0, c};
    it.tag   = tag;
    q.push_back(it);
  endtask

  // monitor: sample on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        vectors++;
        if ({co16, s16} !== it.exp16) begin
          miscompares++;
          $display("FAIL %s (16-bit, R1/R2): got %h expected %h", it.tag, {co16, s16}, it.exp16);
        end
        vectors++;
        if ({co8, s8} !== it.exp8) begin
          miscompares++;
          $display("FAIL %s (8-bit, R3): got %h expected %h", it.tag, {co8, s8}, it.exp8);
        end
      end
    end
  end

  initial begin
    a16 = '0; b16 = '0; a8 = '0; b8 = '0; ci = 1'b0;
    drive(16'h0000, 16'h0000, 1'b0, "R7 zeros");
    drive(16'hFFFF, 16'h0000, 1'b1, "R4 all ones plus cin");
    drive(16'hFFFF, 16'h0001, 1'b0, "R4 all ones plus one");
    drive(16'hAAAA, 16'h5555, 1'b0, "R8 alternating cin0");
    drive(16'hAAAA, 16'h5555, 1'b1, "R8 alternating cin1");
    drive(16'h00FF, 16'h0001, 1'b0, "R6 low segment carry");
    drive(16'h0F00, 16'h0100, 1'b0, "R6 upper carry with low carry 0");
    drive(16'hFF00, 16'h0100, 1'b0, "R5 upper carry without select");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R2 max operands");
    drive(16'h8000, 16'h8000, 1'b0, "R2 top bit carry");
    for (int n = 0; n < 300; n++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule